// File: doc/BRIEF.md
# Designator-Selected Address Register File

This block holds sixteen 16-bit address registers for an 8-bit processor. No register is fixed as the program counter. A 4-bit program designator (P) names the entry that acts as the program counter, and a 4-bit data designator (X) names the entry that acts as the data pointer. The block always drives three registers on its outputs: the entry named by P, the entry named by X, and the entry named by the instruction's low nibble, which enters as `idx_i`.

Each cycle the core presents one decoded operation, a register index and a data byte. The file can do any of these:

- increment or decrement any entry,
- increment or decrement the data-pointer entry,
- read or write either byte of any entry,
- load P or X from the index,
- perform the register side of interrupt entry, of the status push and of return.

For these last three it keeps a saved-state byte T and an interrupt-enable flag. Entry 0 serves as the DMA pointer, entry 1 as the interrupt program counter, and entry 2 as the stack pointer for the status push. Memory access and arithmetic on data are done outside this block.

Top module: `desig_regfile`

## Requirements
- R1: During and after reset, all sixteen registers, P, X and T read zero and the interrupt-enable flag reads 1.
- R2: `rp_o`, `rx_o` and `rn_o` show the current contents of the registers named by P, by X and by `idx_i`, with no clock delay.
- R3: Op code 1 increments and op code 2 decrements the register named by `idx_i`, modulo 2^16 (FFFF+1 gives 0000; 0000-1 gives FFFF).
- R4: Op code 3 increments and op code 4 decrements the register named by X.
- R5: Op code 7 writes `byte_i` into bits 7:0 and op code 8 writes it into bits 15:8 of the register named by `idx_i`, leaving the other byte unchanged.
- R6: `rd_byte_o` carries bits 15:8 of the register named by `idx_i` while the op is 6, and bits 7:0 otherwise (op 5 is the low-byte read). Read ops change no state.
- R7: Op code 9 loads `idx_i` into P and op code 10 loads `idx_i` into X.
- R8: Op code 11 (interrupt entry) copies the packed byte {X,P} into T, sets P to 1 and X to 2, and clears the interrupt-enable flag.
- R9: `xp_o` packs X in bits 7:4 and P in bits 3:0. Op code 12 (status push) copies `xp_o` into T, copies P into X, keeps P, and decrements register 2.
- R10: Op code 13 loads X from `byte_i[7:4]` and P from `byte_i[3:0]`, increments the register named by the old X, and sets the interrupt-enable flag. Op code 14 does the same but clears the flag.
- R11: Op codes 0 and 15 change no register, designator, T or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Decoded operation code |
| idx_i | input | 4 | Register index (instruction low nibble) |
| byte_i | input | 8 | Data byte for writes and returns |
| rp_o | output | 16 | Register named by P (program counter) |
| rx_o | output | 16 | Register named by X (data pointer) |
| rn_o | output | 16 | Register named by `idx_i` |
| rd_byte_o | output | 8 | Selected byte of the `idx_i` register |
| p_o | output | 4 | Program designator |
| x_o | output | 4 | Data designator |
| t_o | output | 8 | Saved-state byte |
| xp_o | output | 8 | Packed {X,P} for the status push write |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
Byte writes use distinct low and high values. A swapped or clobbered half therefore shows up as a wrong value, rather than matching by chance. Increment and decrement are applied to both mid-range and wrap-around values (FFFF and 0000), so a carry that is dropped or leaks into the wrong bit is caught.

The designator-based ops run with P, X and the index all naming different registers, so any mix-up of which entry is touched is visible. Interrupt entry, status push and the two return forms run in a chain. In that chain T, the designators, the flag and register 2 each take a value that only the correct order of updates can produce.

// File: rtl/desig_rf_pkg.sv
// Package: shared operation codes for the designator-selected register file.
// Assumes a 4-bit decoded operation field supplied by the instruction decoder.
package desig_rf_pkg;

    typedef enum logic [3:0] {
        RF_NOP    = 4'h0,
        RF_INC    = 4'h1,
        RF_DEC    = 4'h2,
        RF_INCX   = 4'h3,
        RF_DECX   = 4'h4,
        RF_GETLO  = 4'h5,
        RF_GETHI  = 4'h6,
        RF_PUTLO  = 4'h7,
        RF_PUTHI  = 4'h8,
        RF_SETP   = 4'h9,
        RF_SETX   = 4'hA,
        RF_INTENT = 4'hB,
        RF_MARK   = 4'hC,
        RF_RETEN  = 4'hD,
        RF_RETDIS = 4'hE,
        RF_RSVD   = 4'hF
    } rf_op_e;

endpackage

// File: rtl/rf_step.sv
// Module: rf_step
// Adds or subtracts one from a register value, with wrap-around.
// Assumes unsigned values; overflow wraps modulo 2^W.
module rf_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic         down_i,
    output logic [W-1:0] y_o
);

    // One adder serves both directions: add all-ones to step down.
    always_comb begin
        if (down_i) y_o = a_i + {W{1'b1}};
        else        y_o = a_i + {{(W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/rf_bank.sv
// Module: rf_bank
// Storage for NREG registers: one write port and four combinational read
// ports (program, data, index and write-target views).
// Assumes at most one register is written per cycle.
module rf_bank #(
    parameter int IDX_W = 4,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [IDX_W-1:0] pidx_i,
    input  logic [IDX_W-1:0] xidx_i,
    input  logic [IDX_W-1:0] nidx_i,
    output logic [REG_W-1:0] p_rd_o,
    output logic [REG_W-1:0] x_rd_o,
    output logic [REG_W-1:0] n_rd_o,
    output logic [REG_W-1:0] w_rd_o
);

    localparam int NREG = 1 << IDX_W;

    logic [REG_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        // Each entry loads wdata_i only when it is the selected write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we_i && (widx_i == IDX_W'(g)))
                regs[g] <= wdata_i;
        end
    end

    // Read ports: plain index multiplexers.
    always_comb begin
        p_rd_o = regs[pidx_i];
        x_rd_o = regs[xidx_i];
        n_rd_o = regs[nidx_i];
        w_rd_o = regs[widx_i];
    end

endmodule

// File: rtl/rf_desig.sv
// Module: rf_desig
// Holds the P and X designators, the saved-state byte T and the
// interrupt-enable flag, and applies the op-driven updates to them.
// Assumes the packed byte puts X in the upper half and P in the lower half.
module rf_desig
    import desig_rf_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int INT_PC = 1,
    parameter int INT_SP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rf_op_e             op_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [2*IDX_W-1:0] byte_i,
    output logic [IDX_W-1:0]   p_o,
    output logic [IDX_W-1:0]   x_o,
    output logic [2*IDX_W-1:0] t_o,
    output logic               ie_o
);

    logic [IDX_W-1:0]   p_q, x_q, p_d, x_d;
    logic [2*IDX_W-1:0] t_q, t_d;
    logic               ie_q, ie_d;

    // Next-state selection for the designators, T and the enable flag.
    always_comb begin
        p_d  = p_q;
        x_d  = x_q;
        t_d  = t_q;
        ie_d = ie_q;
        unique case (op_i)
            RF_SETP: p_d = idx_i;
            RF_SETX: x_d = idx_i;
            RF_INTENT: begin
                t_d  = {x_q, p_q};
                p_d  = IDX_W'(INT_PC);
                x_d  = IDX_W'(INT_SP);
                ie_d = 1'b0;
            end
            RF_MARK: begin
                t_d = {x_q, p_q};
                x_d = p_q;
            end
            RF_RETEN: begin
                {x_d, p_d} = byte_i;
                ie_d       = 1'b1;
            end
            RF_RETDIS: begin
                {x_d, p_d} = byte_i;
                ie_d       = 1'b0;
            end
            default: ;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q  <= '0;
            x_q  <= '0;
            t_q  <= '0;
            ie_q <= 1'b1;
        end else begin
            p_q  <= p_d;
            x_q  <= x_d;
            t_q  <= t_d;
            ie_q <= ie_d;
        end
    end

    // Drive the held state out.
    always_comb begin
        p_o  = p_q;
        x_o  = x_q;
        t_o  = t_q;
        ie_o = ie_q;
    end

endmodule

// File: rtl/desig_regfile.sv
// Module: desig_regfile (top)
// Sixteen address registers selected through the P and X designators.
// Decodes the op into a single register write (step or byte put) and
// passes designator updates to rf_desig.
// Assumes one operation per cycle; memory and data arithmetic are outside.
module desig_regfile
    import desig_rf_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int REG_W   = 16,
    parameter int INT_PC  = 1,
    parameter int INT_SP  = 2,
    parameter int MARK_SP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [REG_W/2-1:0]  byte_i,
    output logic [REG_W-1:0]    rp_o,
    output logic [REG_W-1:0]    rx_o,
    output logic [REG_W-1:0]    rn_o,
    output logic [REG_W/2-1:0]  rd_byte_o,
    output logic [IDX_W-1:0]    p_o,
    output logic [IDX_W-1:0]    x_o,
    output logic [2*IDX_W-1:0]  t_o,
    output logic [2*IDX_W-1:0]  xp_o,
    output logic                ie_o
);

    localparam int BYTE_W = REG_W / 2;

    rf_op_e           op;
    logic             we, step_dn, use_step;
    logic [IDX_W-1:0] widx;
    logic [REG_W-1:0] wdata, w_rd, step_y;

    assign op = rf_op_e'(op_i);

    rf_desig #(.IDX_W(IDX_W), .INT_PC(INT_PC), .INT_SP(INT_SP)) u_desig (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .idx_i  (idx_i),
        .byte_i (byte_i),
        .p_o    (p_o),
        .x_o    (x_o),
        .t_o    (t_o),
        .ie_o   (ie_o)
    );

    rf_bank #(.IDX_W(IDX_W), .REG_W(REG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .widx_i  (widx),
        .wdata_i (wdata),
        .pidx_i  (p_o),
        .xidx_i  (x_o),
        .nidx_i  (idx_i),
        .p_rd_o  (rp_o),
        .x_rd_o  (rx_o),
        .n_rd_o  (rn_o),
        .w_rd_o  (w_rd)
    );

    rf_step #(.W(REG_W)) u_step (
        .a_i    (w_rd),
        .down_i (step_dn),
        .y_o    (step_y)
    );

    // Pick the write target, step direction and write source for the op.
    always_comb begin
        we       = 1'b0;
        widx     = idx_i;
        step_dn  = 1'b0;
        use_step = 1'b1;
        unique case (op)
            RF_INC:  we = 1'b1;
            RF_DEC: begin
                we      = 1'b1;
                step_dn = 1'b1;
            end
            RF_INCX, RF_RETEN, RF_RETDIS: begin
                we   = 1'b1;
                widx = x_o;
            end
            RF_DECX: begin
                we      = 1'b1;
                widx    = x_o;
                step_dn = 1'b1;
            end
            RF_MARK: begin
                we      = 1'b1;
                widx    = IDX_W'(MARK_SP);
                step_dn = 1'b1;
            end
            RF_PUTLO, RF_PUTHI: begin
                we       = 1'b1;
                use_step = 1'b0;
            end
            default: ;
        endcase
    end

    // Write data: a stepped value, or the index register with one byte replaced.
    always_comb begin
        if (use_step)
            wdata = step_y;
        else if (op == RF_PUTHI)
            wdata = {byte_i, rn_o[BYTE_W-1:0]};
        else
            wdata = {rn_o[REG_W-1:BYTE_W], byte_i};
    end

    // Byte read port and the packed designator byte.
    always_comb begin
        rd_byte_o = (op == RF_GETHI) ? rn_o[REG_W-1:BYTE_W] : rn_o[BYTE_W-1:0];
        xp_o      = {x_o, p_o};
    end

endmodule

// File: rtl/desig_regfile_chk.sv
// Module: desig_regfile_chk
// Property checker for desig_regfile, attached with bind below.
// Assumes the default 4-bit designators and 16-bit registers.
module desig_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_i,
    input logic [3:0]  idx_i,
    input logic [7:0]  byte_i,
    input logic [15:0] rp_o,
    input logic [15:0] rx_o,
    input logic [3:0]  p_o,
    input logic [3:0]  x_o,
    input logic [7:0]  t_o,
    input logic [7:0]  xp_o,
    input logic        ie_o
);

    logic was_rst_q;

    // Remember whether the previous edge was in reset.
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
    end

    // R1: state right after reset
    always_ff @(posedge clk) begin
        if (was_rst_q === 1'b1 && rst_n)
            assert_reset_state_R1: assert (p_o == 4'h0 && x_o == 4'h0 && t_o == 8'h00 && ie_o);
    end

    assert_incx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'h3 |=> rx_o == $past(rx_o) + 16'd1);

    assert_decx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'h4 |=> rx_o == $past(rx_o) - 16'd1);

    assert_set_p_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'h9 |=> p_o == $past(idx_i));

    assert_set_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'hA |=> x_o == $past(idx_i));

    assert_int_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'hB |=> (p_o == 4'h1 && x_o == 4'h2 && !ie_o && t_o == $past(xp_o)));

    assert_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'hC |=> (x_o == $past(p_o) && p_o == $past(p_o) && t_o == $past(xp_o)));

    assert_ret_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'hD |=> ({x_o, p_o} == $past(byte_i) && ie_o));

    assert_ret_dis_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'hE |=> ({x_o, p_o} == $past(byte_i) && !ie_o));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'h0 || op_i == 4'hF) |=>
        ($stable(p_o) && $stable(x_o) && $stable(t_o) && $stable(ie_o) && $stable(rp_o) && $stable(rx_o)));

    assert_read_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'h5 || op_i == 4'h6) |=>
        ($stable(p_o) && $stable(x_o) && $stable(t_o) && $stable(rp_o) && $stable(rx_o)));

endmodule

bind desig_regfile desig_regfile_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .idx_i  (idx_i),
    .byte_i (byte_i),
    .rp_o   (rp_o),
    .rx_o   (rx_o),
    .p_o    (p_o),
    .x_o    (x_o),
    .t_o    (t_o),
    .xp_o   (xp_o),
    .ie_o   (ie_o)
);

// File: tb/tb_desig_regfile.sv
// Bench for desig_regfile: a table of vectors walked by one loop, then
// directed reset checks. Inputs change on the falling edge; results are
// read just after the following falling edge.
module tb_desig_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'h0;
    logic [3:0]  idx_i = 4'h0;
    logic [7:0]  byte_i = 8'h00;
    logic [15:0] rp_o, rx_o, rn_o;
    logic [7:0]  rd_byte_o, t_o, xp_o;
    logic [3:0]  p_o, x_o;
    logic        ie_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    desig_regfile dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .idx_i     (idx_i),
        .byte_i    (byte_i),
        .rp_o      (rp_o),
        .rx_o      (rx_o),
        .rn_o      (rn_o),
        .rd_byte_o (rd_byte_o),
        .p_o       (p_o),
        .x_o       (x_o),
        .t_o       (t_o),
        .xp_o      (xp_o),
        .ie_o      (ie_o)
    );

    // Vector: op, idx, byte, what, check idx, expected, requirement number.
    // what: 0 rn(cidx) 1 p 2 x 3 t 4 ie 5 rp 6 rx 7 rd_byte 8 xp
    localparam int NV = 36;
    localparam logic [47:0] VEC [NV] = '{
        {4'h7, 4'h3, 8'h34, 4'h0, 4'h3, 16'h0034, 8'd5},  // R5 low put
        {4'h8, 4'h3, 8'h12, 4'h0, 4'h3, 16'h1234, 8'd5},  // R5 high put keeps low
        {4'h6, 4'h3, 8'h00, 4'h7, 4'h3, 16'h0012, 8'd6},  // R6 high read
        {4'h5, 4'h3, 8'h00, 4'h7, 4'h3, 16'h0034, 8'd6},  // R6 low read
        {4'h1, 4'h3, 8'h00, 4'h0, 4'h3, 16'h1235, 8'd3},  // R3 increment
        {4'h2, 4'h0, 8'h00, 4'h0, 4'h0, 16'hFFFF, 8'd3},  // R3 decrement wraps
        {4'h1, 4'h0, 8'h00, 4'h0, 4'h0, 16'h0000, 8'd3},  // R3 increment wraps
        {4'h7, 4'h5, 8'hFF, 4'h0, 4'h5, 16'h00FF, 8'd5},  // R5
        {4'h8, 4'h5, 8'hFF, 4'h0, 4'h5, 16'hFFFF, 8'd5},  // R5
        {4'h1, 4'h5, 8'h00, 4'h0, 4'h5, 16'h0000, 8'd3},  // R3 full wrap
        {4'hA, 4'h3, 8'h00, 4'h2, 4'h0, 16'h0003, 8'd7},  // R7 set X
        {4'h0, 4'h0, 8'h00, 4'h6, 4'h0, 16'h1235, 8'd2},  // R2 data view
        {4'h3, 4'h9, 8'h00, 4'h6, 4'h0, 16'h1236, 8'd4},  // R4 inc via X
        {4'h4, 4'h9, 8'h00, 4'h6, 4'h0, 16'h1235, 8'd4},  // R4 dec via X
        {4'h9, 4'h3, 8'h00, 4'h5, 4'h0, 16'h1235, 8'd2},  // R2 program view
        {4'h9, 4'h7, 8'h00, 4'h1, 4'h0, 16'h0007, 8'd7},  // R7 set P
        {4'hB, 4'h0, 8'h00, 4'h3, 4'h0, 16'h0037, 8'd8},  // R8 T saved
        {4'h0, 4'h0, 8'h00, 4'h1, 4'h0, 16'h0001, 8'd8},  // R8 P=1
        {4'h0, 4'h0, 8'h00, 4'h2, 4'h0, 16'h0002, 8'd8},  // R8 X=2
        {4'h0, 4'h0, 8'h00, 4'h4, 4'h0, 16'h0000, 8'd8},  // R8 flag off
        {4'h7, 4'h2, 8'h00, 4'h0, 4'h2, 16'h0000, 8'd5},  // R5
        {4'h8, 4'h2, 8'h40, 4'h0, 4'h2, 16'h4000, 8'd5},  // R5
        {4'hC, 4'h0, 8'h00, 4'h3, 4'h0, 16'h0021, 8'd9},  // R9 T packed
        {4'h0, 4'h0, 8'h00, 4'h2, 4'h0, 16'h0001, 8'd9},  // R9 X=P
        {4'h0, 4'h0, 8'h00, 4'h1, 4'h0, 16'h0001, 8'd9},  // R9 P kept
        {4'h0, 4'h2, 8'h00, 4'h0, 4'h2, 16'h3FFF, 8'd9},  // R9 reg 2 down
        {4'hD, 4'h0, 8'h37, 4'h2, 4'h0, 16'h0003, 8'd10}, // R10 X from byte
        {4'h0, 4'h0, 8'h00, 4'h1, 4'h0, 16'h0007, 8'd10}, // R10 P from byte
        {4'h0, 4'h0, 8'h00, 4'h4, 4'h0, 16'h0001, 8'd10}, // R10 flag on
        {4'h0, 4'h1, 8'h00, 4'h0, 4'h1, 16'h0001, 8'd10}, // R10 old X reg up
        {4'hE, 4'h0, 8'h5A, 4'h8, 4'h0, 16'h005A, 8'd10}, // R10 and R9 packing
        {4'h0, 4'h0, 8'h00, 4'h4, 4'h0, 16'h0000, 8'd10}, // R10 flag off
        {4'h0, 4'h3, 8'h00, 4'h0, 4'h3, 16'h1236, 8'd10}, // R10 old X reg up
        {4'hF, 4'h3, 8'hFF, 4'h0, 4'h3, 16'h1236, 8'd11}, // R11 reserved code
        {4'h0, 4'h0, 8'h00, 4'h8, 4'h0, 16'h005A, 8'd11}, // R11 designators kept
        {4'h5, 4'h3, 8'h00, 4'h0, 4'h3, 16'h1236, 8'd6}   // R6 read changes nothing
    };

    task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] view(input logic [3:0] w, input logic [7:0] rd_now);
        case (w)
            4'h0: view = rn_o;
            4'h1: view = {12'h0, p_o};
            4'h2: view = {12'h0, x_o};
            4'h3: view = {8'h0, t_o};
            4'h4: view = {15'h0, ie_o};
            4'h5: view = rp_o;
            4'h6: view = rx_o;
            4'h7: view = {8'h0, rd_now};
            default: view = {8'h0, xp_o};
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state out of reset
        check(1, "reset P", {12'h0, p_o}, 16'h0);
        check(1, "reset X", {12'h0, x_o}, 16'h0);
        check(1, "reset T", {8'h0, t_o}, 16'h0);
        check(1, "reset flag", {15'h0, ie_o}, 16'h1);
        check(1, "reset reg", rn_o, 16'h0);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] rd_now;
            @(negedge clk);
            op_i   = VEC[v][47:44];
            idx_i  = VEC[v][43:40];
            byte_i = VEC[v][39:32];
            #1;
            rd_now = rd_byte_o;
            @(negedge clk);
            op_i   = 4'h0;
            idx_i  = VEC[v][27:24];
            byte_i = 8'h00;
            #1;
            check(int'(VEC[v][7:0]), $sformatf("vector %0d", v),
                  view(VEC[v][31:28], rd_now), VEC[v][23:8]);
        end

        // R1: reset in mid-run clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1, "rerun P", {12'h0, p_o}, 16'h0);
        check(1, "rerun X", {12'h0, x_o}, 16'h0);
        check(1, "rerun T", {8'h0, t_o}, 16'h0);
        check(1, "rerun flag", {15'h0, ie_o}, 16'h1);
        for (int i = 0; i < 16; i++) begin
            idx_i = 4'(i);
            #1;
            check(1, $sformatf("rerun reg %0d", i), rn_o, 16'h0);
        end

        // R3 and R2: decrement the program register 0 through wrap
        @(negedge clk);
        op_i = 4'h2; idx_i = 4'h0;
        @(negedge clk);
        op_i = 4'h0;
        #1;
        check(3, "pc view after wrap", rp_o, 16'hFFFF);
        check(2, "data view same reg", rx_o, 16'hFFFF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule